// File: doc/BRIEF.md
# Indexed Clock Register Port

This block is the host side of a real-time clock. It gives a byte-wide bus access to a 128-byte register space through two addresses. A write to the even address picks one of the 128 byte locations. An access to the odd address then reads or writes that byte. The space holds the current time and calendar bytes, three alarm bytes, four control and status registers, and general-purpose storage.

The block applies a separate access rule to each register:
- Some bits are read-only.
- Some registers ignore writes.
- The interrupt status register clears itself when it is read.
- The set-mode control bit freezes the calendar engine's copy of the time.

The control fields, the alarm bytes and the time bytes are exported to a separate calendar engine. That engine counts time and produces the periodic timebase; neither function is part of this block. The engine returns three things to this block: update-in-progress notices, fresh time snapshots and interrupt events.

Host accesses use single-cycle read and write strobes. Read data is registered and is valid in the cycle after the read strobe.

Top module: `clkreg_host_port`

## Requirements
- R1: A write to address 0 stores bits 6:0 of the data as the index, and bit 7 is dropped. A read of address 0 returns 0xFF on `host_rdata` one cycle after the strobe.
- R2: A read of address 1 returns the byte at the current index one cycle after the strobe. The alarm bytes at index 1, 3 and 5 return the last value written. Index 14 to 127 is plain storage and also returns the last value written.
- R3: Bit 7 of control register A (index 10) is the update-in-progress flag. A host write leaves it unchanged, and bits 6:0 take the written data. Bits 6:4 and 3:0 are exported as the oscillator field and the rate field.
- R4: A host write to control register B (index 11) with bit 7 (set mode) high does two things. It stores bit 4 (update-ended enable) as 0, and it clears the update-in-progress flag.
- R5: Register C (index 12) and register D (index 13) ignore host writes. A later read returns the value they held before the write.
- R6: A read of register C returns its current value. The register then becomes 0x00, and `irq_o` goes low in the cycle after the read. An event that arrives in the same cycle as the read is kept.
- R7: The time bytes are at index 0, 2, 4, 6, 7, 8 and 9: seconds, minutes, hours, weekday, day, month, year. They are packed into `time_o` in that order, seconds in bits 7:0.
  - A host write to a time byte while set mode is clear raises `tload_o` for one cycle in the next cycle. `time_o` already carries the new byte in that cycle.
  - While set mode is high, such a write raises no pulse.
  - A write to register B that clears a set-mode bit that was high raises the pulse.
- R8: After reset, the registers hold these values, and `irq_o` and `tload_o` are low:

  | Register | Reset value |
  |---|---|
  | A | 0x26 |
  | B | 0x02 |
  | C | 0x00 |
  | D | 0x80 |

  Register B bits 6, 5 and 3 are therefore clear. These are the periodic, alarm and square-wave enables.
- R9: The event inputs set flags in register C:

  | Event input | C flag bit | Enable bit in B |
  |---|---|---|
  | `evt_periodic_i` | 6 | 6 |
  | `evt_alarm_i` | 5 | 5 |
  | `evt_update_i` | 4 | 4 |

  C bit 7 (the interrupt flag) and `irq_o` are set only when the matching enable bit in B is set.
- R10: Handling of the engine inputs depends on set mode:
  - `eng_upd_i` copies `eng_time_i` into the seven time bytes when set mode is clear. It is ignored while set mode is high.
  - `eng_upd_i` always clears the update-in-progress flag.
  - `eng_uip_i` sets the update-in-progress flag only while set mode is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_addr | input | 1 | 0 selects the index, 1 selects the data byte |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt line, which follows the interrupt flag in C |
| ctl_a_o | output | 8 | Control register A |
| ctl_b_o | output | 8 | Control register B |
| alarm_o | output | 24 | Alarm bytes: hours, minutes, seconds, from the high byte to the low byte |
| time_o | output | 56 | Time bytes as packed in R7 |
| tload_o | output | 1 | One-cycle pulse: the engine should load `time_o` |
| eng_uip_i | input | 1 | Engine announces that an update has started |
| eng_upd_i | input | 1 | Engine delivers a new time snapshot |
| eng_time_i | input | 56 | Snapshot, packed as `time_o` |
| evt_periodic_i | input | 1 | Periodic event pulse |
| evt_alarm_i | input | 1 | Alarm-match event pulse |
| evt_update_i | input | 1 | Update-ended event pulse |

## Verification
The checker watches a set of cycle-local rules on every cycle:
- an index-port read always yields 0xFF;
- a data write to register A keeps the update-in-progress flag;
- a write to register B with set mode high leaves bit 4 and the update-in-progress flag clear;
- a write to C with no events pending leaves C unchanged;
- a read of C with no events pending empties C and drops the line;
- `tload_o` is never high while set mode is high;
- a snapshot taken while set mode is clear shows up on `time_o`.

Other behaviours need the bench's scenarios, because they span several accesses:
- that the index masking selects the right byte;
- that storage keeps random data;
- that a write frozen under set mode reaches the engine only when set mode is released;
- that the flags collect across several events before a read clears them.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
  localparam int DW      = 8;
  localparam int IW      = 7;
  localparam int NTIME   = 7;
  localparam int NALARM  = 3;

  localparam logic [IW-1:0] IX_CTL_A = 7'd10;
  localparam logic [IW-1:0] IX_CTL_B = 7'd11;
  localparam logic [IW-1:0] IX_CTL_C = 7'd12;
  localparam logic [IW-1:0] IX_CTL_D = 7'd13;

  localparam logic [DW-1:0] RST_A = 8'h26;
  localparam logic [DW-1:0] RST_B = 8'h02;
  localparam logic [DW-1:0] RST_C = 8'h00;
  localparam logic [DW-1:0] RST_D = 8'h80;

  // index of the k-th time byte: sec, min, hr, wday, mday, mon, year
  function automatic logic [IW-1:0] time_slot(input int k);
    return (k < 3) ? IW'(2 * k) : IW'(k + 3);
  endfunction

  // index of the k-th alarm byte: sec, min, hr
  function automatic logic [IW-1:0] alarm_slot(input int k);
    return IW'(2 * k + 1);
  endfunction

  function automatic logic is_time_idx(input logic [IW-1:0] ix);
    return (ix == 7'd0) || (ix == 7'd2) || (ix == 7'd4) ||
           ((ix >= 7'd6) && (ix <= 7'd9));
  endfunction

  function automatic logic is_ctl_idx(input logic [IW-1:0] ix);
    return (ix >= IX_CTL_A) && (ix <= IX_CTL_D);
  endfunction

  // stored value of B after a host write: set mode forces bit 4 low
  function automatic logic [DW-1:0] b_filter(input logic [DW-1:0] din);
    return din[7] ? (din & 8'hEF) : din;
  endfunction
endpackage

// File: rtl/clkreg_ctrl.sv
module clkreg_ctrl
  import clkreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [DW-1:0] wdata,
  input  logic          rd_c,
  input  logic          evt_per,
  input  logic          evt_alm,
  input  logic          evt_upd,
  input  logic          uip_set,
  input  logic          upd_done,
  output logic [DW-1:0] reg_a,
  output logic [DW-1:0] reg_b,
  output logic [DW-1:0] reg_c,
  output logic [DW-1:0] reg_d,
  output logic          set_leave
);
  logic          uip_q;
  logic [6:0]    a_low_q;
  logic [DW-1:0] b_q;
  logic [DW-1:0] c_q;
  logic [2:0]    ev_vec;
  logic [2:0]    en_vec;
  logic [DW-1:0] c_next;

  assign ev_vec    = {evt_per, evt_alm, evt_upd};
  assign en_vec    = {b_q[6], b_q[5], b_q[4]};
  assign set_leave = wr_b && !wdata[7] && b_q[7];

  always_comb begin
    c_next      = rd_c ? '0 : c_q;
    c_next[6:4] = c_next[6:4] | ev_vec;
    c_next[7]   = c_next[7] | (|(ev_vec & en_vec));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uip_q   <= RST_A[7];
      a_low_q <= RST_A[6:0];
      b_q     <= RST_B;
      c_q     <= RST_C;
    end else begin
      if (wr_a) a_low_q <= wdata[6:0];
      if (wr_b) b_q <= b_filter(wdata);
      if (wr_b && wdata[7])      uip_q <= 1'b0;
      else if (upd_done)         uip_q <= 1'b0;
      else if (uip_set && !b_q[7]) uip_q <= 1'b1;
      c_q <= c_next;
    end
  end

  assign reg_a = {uip_q, a_low_q};
  assign reg_b = b_q;
  assign reg_c = c_q;
  assign reg_d = RST_D;
endmodule

// File: rtl/clkreg_store.sv
module clkreg_store
  import clkreg_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      idx,
  input  logic [DW-1:0]      wdata,
  input  logic               eng_load,
  input  logic [NTIME*DW-1:0] eng_time,
  output logic [DW-1:0]      rd_byte,
  output logic [NTIME*DW-1:0] time_out,
  output logic [NALARM*DW-1:0] alarm_out
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (eng_load)
        for (int k = 0; k < NTIME; k++) mem[time_slot(k)] <= eng_time[k*DW +: DW];
      if (wr_en) mem[idx] <= wdata;
    end
  end

  assign rd_byte = mem[idx];

  for (genvar k = 0; k < NTIME; k++) begin : g_time
    assign time_out[k*DW +: DW] = mem[time_slot(k)];
  end
  for (genvar k = 0; k < NALARM; k++) begin : g_alarm
    assign alarm_out[k*DW +: DW] = mem[alarm_slot(k)];
  end
endmodule

// File: rtl/clkreg_host_port.sv
module clkreg_host_port
  import clkreg_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic                 host_addr,
  input  logic [DW-1:0]        host_wdata,
  output logic [DW-1:0]        host_rdata,
  output logic                 irq_o,
  output logic [DW-1:0]        ctl_a_o,
  output logic [DW-1:0]        ctl_b_o,
  output logic [NALARM*DW-1:0] alarm_o,
  output logic [NTIME*DW-1:0]  time_o,
  output logic                 tload_o,
  input  logic                 eng_uip_i,
  input  logic                 eng_upd_i,
  input  logic [NTIME*DW-1:0]  eng_time_i,
  input  logic                 evt_periodic_i,
  input  logic                 evt_alarm_i,
  input  logic                 evt_update_i
);
  logic [IW-1:0] idx_q;
  logic [DW-1:0] rdata_q;
  logic          tload_q;
  logic [DW-1:0] reg_a, reg_b, reg_c, reg_d, mem_byte;

  // named access events
  logic wr_idx_ev, wr_dat_ev, rd_dat_ev;
  logic wr_a_ev, wr_b_ev, rd_c_ev, wr_mem_ev, wr_time_ev;
  logic set_mode, set_leave, eng_load;

  assign wr_idx_ev  = host_wr && !host_addr;
  assign wr_dat_ev  = host_wr && host_addr;
  assign rd_dat_ev  = host_rd && host_addr;
  assign wr_a_ev    = wr_dat_ev && (idx_q == IX_CTL_A);
  assign wr_b_ev    = wr_dat_ev && (idx_q == IX_CTL_B);
  assign rd_c_ev    = rd_dat_ev && (idx_q == IX_CTL_C);
  assign wr_mem_ev  = wr_dat_ev && !is_ctl_idx(idx_q);
  assign wr_time_ev = wr_dat_ev && is_time_idx(idx_q);
  assign set_mode   = reg_b[7];
  assign eng_load   = eng_upd_i && !set_mode;

  clkreg_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_a     (wr_a_ev),
    .wr_b     (wr_b_ev),
    .wdata    (host_wdata),
    .rd_c     (rd_c_ev),
    .evt_per  (evt_periodic_i),
    .evt_alm  (evt_alarm_i),
    .evt_upd  (evt_update_i),
    .uip_set  (eng_uip_i),
    .upd_done (eng_upd_i),
    .reg_a    (reg_a),
    .reg_b    (reg_b),
    .reg_c    (reg_c),
    .reg_d    (reg_d),
    .set_leave(set_leave)
  );

  clkreg_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_mem_ev),
    .idx      (idx_q),
    .wdata    (host_wdata),
    .eng_load (eng_load),
    .eng_time (eng_time_i),
    .rd_byte  (mem_byte),
    .time_out (time_o),
    .alarm_out(alarm_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      rdata_q <= '0;
      tload_q <= 1'b0;
    end else begin
      if (wr_idx_ev) idx_q <= host_wdata[IW-1:0];
      if (host_rd) begin
        if (!host_addr) rdata_q <= 8'hFF;
        else begin
          case (idx_q)
            IX_CTL_A: rdata_q <= reg_a;
            IX_CTL_B: rdata_q <= reg_b;
            IX_CTL_C: rdata_q <= reg_c;
            IX_CTL_D: rdata_q <= reg_d;
            default:  rdata_q <= mem_byte;
          endcase
        end
      end
      tload_q <= (wr_time_ev && !set_mode) || set_leave;
    end
  end

  assign host_rdata = rdata_q;
  assign tload_o    = tload_q;
  assign irq_o      = reg_c[7];
  assign ctl_a_o    = reg_a;
  assign ctl_b_o    = reg_b;
endmodule

// File: rtl/clkreg_host_port_chk.sv
module clkreg_host_port_chk
  import clkreg_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                host_rd,
  input logic                host_addr,
  input logic [DW-1:0]       host_wdata,
  input logic [DW-1:0]       host_rdata,
  input logic                irq_o,
  input logic [DW-1:0]       ctl_a_o,
  input logic [DW-1:0]       ctl_b_o,
  input logic [NTIME*DW-1:0] time_o,
  input logic                tload_o,
  input logic [NTIME*DW-1:0] eng_time_i,
  input logic                eng_uip_i,
  input logic                eng_upd_i,
  input logic                evt_periodic_i,
  input logic                evt_alarm_i,
  input logic                evt_update_i,
  input logic                wr_a_ev,
  input logic                wr_b_ev,
  input logic                wr_dat_ev,
  input logic                rd_c_ev,
  input logic [DW-1:0]       reg_c
);
  logic any_evt;
  assign any_evt = evt_periodic_i || evt_alarm_i || evt_update_i;

  // R1
  idx_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_addr |=> host_rdata == 8'hFF);

  // R3
  uip_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a_ev && !eng_uip_i && !eng_upd_i |=> ctl_a_o[7] == $past(ctl_a_o[7]));

  // R4
  set_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b_ev && host_wdata[7] |=> !ctl_b_o[4] && !ctl_a_o[7]);

  // R5
  c_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat_ev && !rd_c_ev && !any_evt |=> $stable(reg_c));

  // R6
  c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c_ev && !any_evt |=> reg_c == 8'h00 && !irq_o);

  // R7
  tload_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tload_o |-> !ctl_b_o[7]);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(any_evt));

  // R10
  snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_upd_i && !ctl_b_o[7] && !wr_dat_ev |=> time_o == $past(eng_time_i));
endmodule

bind clkreg_host_port clkreg_host_port_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_rd       (host_rd),
  .host_addr     (host_addr),
  .host_wdata    (host_wdata),
  .host_rdata    (host_rdata),
  .irq_o         (irq_o),
  .ctl_a_o       (ctl_a_o),
  .ctl_b_o       (ctl_b_o),
  .time_o        (time_o),
  .tload_o       (tload_o),
  .eng_time_i    (eng_time_i),
  .eng_uip_i     (eng_uip_i),
  .eng_upd_i     (eng_upd_i),
  .evt_periodic_i(evt_periodic_i),
  .evt_alarm_i   (evt_alarm_i),
  .evt_update_i  (evt_update_i),
  .wr_a_ev       (wr_a_ev),
  .wr_b_ev       (wr_b_ev),
  .wr_dat_ev     (wr_dat_ev),
  .rd_c_ev       (rd_c_ev),
  .reg_c         (reg_c)
);

// File: tb/clkreg_host_port_test.sv
module clkreg_host_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 0, host_rd = 0, host_addr = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic        irq_o, tload_o;
  logic [7:0]  ctl_a_o, ctl_b_o;
  logic [23:0] alarm_o;
  logic [55:0] time_o;
  logic        eng_uip_i = 0, eng_upd_i = 0;
  logic [55:0] eng_time_i = '0;
  logic        evt_periodic_i = 0, evt_alarm_i = 0, evt_update_i = 0;

  int checks = 0, errors = 0;
  logic [7:0] exp_mem [128];
  logic [7:0] rv;

  always #5 clk = ~clk;

  clkreg_host_port uut (.*);

  function automatic logic [7:0] exp_b_store(input logic [7:0] d);
    return d[7] ? {d[7:5], 1'b0, d[3:0]} : d;
  endfunction

  function automatic logic [7:0] exp_a_store(input logic [7:0] old, input logic [7:0] d);
    return {old[7], d[6:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic rd_ix(input logic [6:0] ix, output logic [7:0] d);
    wr(1'b0, {1'b0, ix});
    rd(1'b1, d);
  endtask

  task automatic wr_ix(input logic [6:0] ix, input logic [7:0] d);
    wr(1'b0, {1'b0, ix});
    wr(1'b1, d);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evt_periodic_i = 1;
      1: evt_alarm_i = 1;
      2: evt_update_i = 1;
      3: eng_uip_i = 1;
      default: eng_upd_i = 1;
    endcase
    @(negedge clk);
    evt_periodic_i = 0; evt_alarm_i = 0; evt_update_i = 0; eng_uip_i = 0; eng_upd_i = 0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    chk("R8 irq", irq_o, 0);
    chk("R8 tload", tload_o, 0);
    rd_ix(7'd10, rv); chk("R8 A", rv, 8'h26);
    rd_ix(7'd11, rv); chk("R8 B", rv, 8'h02);
    rd_ix(7'd12, rv); chk("R8 C", rv, 8'h00);
    rd_ix(7'd13, rv); chk("R8 D", rv, 8'h80);

    // R1 index masking and even-address read
    wr_ix(7'd127, 8'h5A);
    wr(1'b0, 8'hFF);
    rd(1'b1, rv); chk("R1 mask", rv, 8'h5A);
    rd(1'b0, rv); chk("R1 even read", rv, 8'hFF);

    // R2 random storage and alarms
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'h00;
    exp_mem[127] = 8'h5A;
    for (int n = 0; n < 60; n++) begin
      logic [6:0] ix;
      logic [7:0] d;
      ix = 7'(14 + ($urandom % 114));
      if (n % 10 == 0) ix = 7'(2 * ($urandom % 3) + 1);
      d = 8'($urandom);
      wr_ix(ix, d);
      exp_mem[ix] = d;
    end
    for (int n = 0; n < 40; n++) begin
      logic [6:0] ix;
      ix = 7'(14 + ($urandom % 114));
      if (n % 8 == 0) ix = 7'(2 * ($urandom % 3) + 1);
      rd_ix(ix, rv); chk("R2 storage", rv, exp_mem[ix]);
    end
    chk("R2 alarm export", alarm_o, {exp_mem[5], exp_mem[3], exp_mem[1]});

    // R3 update-in-progress bit is read-only
    wr_ix(7'd10, 8'hFF);
    rd(1'b1, rv); chk("R3 A write", rv, exp_a_store(8'h26, 8'hFF));
    pulse(3);
    rd(1'b1, rv); chk("R3 uip set", rv, 8'hFF);
    wr(1'b1, 8'h26);
    rd(1'b1, rv); chk("R3 A keep uip", rv, 8'hA6);
    pulse(4);
    rd(1'b1, rv); chk("R10 upd clears uip", rv, 8'h26);

    // R4 set mode side effects
    pulse(3);
    wr_ix(7'd11, 8'h92);
    rd(1'b1, rv); chk("R4 B stored", rv, exp_b_store(8'h92));
    rd_ix(7'd10, rv); chk("R4 uip cleared", rv, 8'h26);

    // R10 engine ignored while set mode
    pulse(3);
    rd(1'b1, rv); chk("R10 uip ignored in set", rv, 8'h26);
    eng_time_i = 56'h11_22_33_44_55_66_77;
    pulse(4);
    chk("R10 snapshot ignored", time_o, 56'h0);

    // R7 frozen write, then release
    wr_ix(7'd0, 8'h45);
    chk("R7 no pulse in set", tload_o, 0);
    wr_ix(7'd11, 8'h02);
    chk("R7 pulse on release", tload_o, 1);
    chk("R7 time on release", time_o[7:0], 8'h45);
    @(negedge clk); chk("R7 single pulse", tload_o, 0);
    wr_ix(7'd2, 8'h30);
    chk("R7 live pulse", tload_o, 1);
    chk("R7 live data", time_o[15:8], 8'h30);

    // R10 snapshot while running
    eng_time_i = 56'h24_12_31_05_23_59_58;
    pulse(4);
    chk("R10 snapshot", time_o, 56'h24_12_31_05_23_59_58);
    rd_ix(7'd4, rv); chk("R10 hours byte", rv, 8'h23);
    rd_ix(7'd9, rv); chk("R10 year byte", rv, 8'h24);

    // R9 flags and enables
    wr_ix(7'd11, 8'h42);
    pulse(1);
    chk("R9 alarm no irq", irq_o, 0);
    pulse(0);
    chk("R9 periodic irq", irq_o, 1);
    // R6 clear on read
    rd_ix(7'd12, rv); chk("R6 C value", rv, 8'hE0);
    chk("R6 irq low", irq_o, 0);
    rd(1'b1, rv); chk("R6 C cleared", rv, 8'h00);
    pulse(2);
    rd(1'b1, rv); chk("R9 update no enable", rv, 8'h10);

    // R5 C and D ignore writes
    pulse(1);
    wr(1'b1, 8'h00);
    wr_ix(7'd12, 8'hFF);
    rd(1'b1, rv); chk("R5 C write ignored", rv, 8'h20);
    wr_ix(7'd13, 8'h00);
    rd(1'b1, rv); chk("R5 D write ignored", rv, 8'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule